// File: doc/BRIEF.md
# Memory-to-Memory Copy Channel

This block is one physical copy engine for moving a run of bytes from one place in memory to another. Software sets it up through a small register port. It writes a 64-bit source address and a 64-bit destination address, each as two 32-bit halves, then a byte count, and then sets the go bit. The engine then walks the range over a word-wide memory request port. Each step reads one 4-byte word and writes the wanted bytes into one destination word, with a byte-enable mask. Source and destination may sit at any byte alignment.

When the last byte has been written, the go bit reads back as 0 and a completion flag is set. The flag drives the interrupt output through an enable bit. Software can also stop a running copy in three ways. A graceful stop finishes the current word and then halts. A warm abort stops at once and keeps the programmed values. A hard abort stops at once and zeroes every register.

Top module: `m2m_copy_chan`

## Requirements
- R1: Register offsets (byte addresses) and fields: interrupt enable at 0x04, bit 0. Source address bits 31:0 at 0x1C and bits 63:32 at 0x60. Destination address bits 31:0 at 0x20 and bits 63:32 at 0x64. Byte count at 0x24, bits 27:0, with bits 31:28 reading 0. Every register reads 0 after rst_n.
- R2: Writing 1 to bit 0 of 0x08 while idle, with a nonzero count, starts a copy. Bit 0 of 0x08 reads 1 while the copy runs and 0 once the last byte is written.
- R3: After a copy, destination bytes 0..count-1 equal the source bytes and no other byte has changed, for any source and destination byte alignment. Every request carries the programmed upper 32 address bits.
- R4: Every memory request address has bits 1:0 at zero. Reads assert all four byte enables. Writes assert only the lanes that hold bytes of the copy range, and at least one of them. A request held without ready keeps its address and direction.
- R5: The completion flag is bit 0 of 0x00 and is set when a copy finishes. Writing 1 to it clears it, and writing 0 leaves it unchanged. If completion and a clear fall in the same cycle, the flag ends up set.
- R6: irq is high exactly when the completion flag and the enable bit (0x04 bit 0) are both 1. It follows a change to either one in the same cycle.
- R7: Starting with a count of 0 sets the completion flag at once and issues no memory request.
- R8: Writing 1 to bit 0 of 0x0C (warm abort) stops a running copy at once. The engine goes idle, no further request is issued, the flag stays clear, and the address, count and enable registers keep their values.
- R9: Writing 1 to bit 1 of 0x0C (hard abort) stops a running copy and zeroes every register, including the flag and the interrupt enable.
- R10: Writing 1 to bit 0 of 0x14 while a copy runs lets the word step in progress finish its write and then stops. The flag is set, and bytes after that step are not written.
- R11: A write of 1 to 0x08 while a copy is running is ignored. The copy finishes unchanged and no extra requests follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| irq | output | 1 | Completion interrupt |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | 64 | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data, lane n in bits 8n+7:8n |
| mem_req_be | output | 4 | Byte enables per lane |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
Two events can land on the completion flag at the same clock edge: the hardware sets it when the final write is accepted, and software writes 1 to clear it. The bench creates this collision on purpose. It holds ready low on the last write of a one-word copy. Then, on a single falling edge, it raises ready and presents the clear write, so both reach the same rising edge. The flag must read 1 afterwards. A second, separate clear must then bring it to 0.

// File: rtl/m2m_copy_pkg.sv
package m2m_copy_pkg;

   localparam int CFG_W = 32;

   // register byte offsets
   localparam logic [7:0] OFS_FLAG   = 8'h00;
   localparam logic [7:0] OFS_IEN    = 8'h04;
   localparam logic [7:0] OFS_GO     = 8'h08;
   localparam logic [7:0] OFS_RST    = 8'h0C;
   localparam logic [7:0] OFS_STOP   = 8'h14;
   localparam logic [7:0] OFS_SRC_LO = 8'h1C;
   localparam logic [7:0] OFS_DST_LO = 8'h20;
   localparam logic [7:0] OFS_LEN    = 8'h24;
   localparam logic [7:0] OFS_SRC_HI = 8'h60;
   localparam logic [7:0] OFS_DST_HI = 8'h64;

   typedef enum logic [1:0] {
      MV_IDLE = 2'd0,
      MV_RD   = 2'd1,
      MV_WAIT = 2'd2,
      MV_WR   = 2'd3
   } mv_state_e;

   // one-cycle command pulses decoded from register writes
   typedef struct packed {
      logic start;
      logic warm;
      logic hard;
      logic stop;
   } cmd_t;

endpackage

// File: rtl/m2m_csr.sv
module m2m_csr import m2m_copy_pkg::*; #(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 28,
   parameter int REG_AW = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [REG_AW-1:0]   cfg_addr,
   input  logic [CFG_W-1:0]    cfg_wdata,
   output logic [CFG_W-1:0]    cfg_rdata,
   input  logic                busy,
   input  logic                done,
   output cmd_t                cmd,
   output logic [ADDR_W-1:0]   src_addr,
   output logic [ADDR_W-1:0]   dst_addr,
   output logic [LEN_W-1:0]    len_val,
   output logic                irq_flag,
   output logic                irq_en
);
   localparam int HI_W = ADDR_W - CFG_W;

   logic [CFG_W-1:0] src_lo_q, dst_lo_q;
   logic [HI_W-1:0]  src_hi_q, dst_hi_q;
   logic [LEN_W-1:0] len_q;
   logic             flag_q, ien_q;

   function automatic logic hit(input logic [7:0] ofs);
      return cfg_we && (cfg_addr == REG_AW'(ofs));
   endfunction

   always_comb begin
      cmd.start = hit(OFS_GO)   && cfg_wdata[0];
      cmd.warm  = hit(OFS_RST)  && cfg_wdata[0];
      cmd.hard  = hit(OFS_RST)  && cfg_wdata[1];
      cmd.stop  = hit(OFS_STOP) && cfg_wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_lo_q <= '0; dst_lo_q <= '0; src_hi_q <= '0; dst_hi_q <= '0;
         len_q <= '0; flag_q <= 1'b0; ien_q <= 1'b0;
      end else if (cmd.hard) begin
         src_lo_q <= '0; dst_lo_q <= '0; src_hi_q <= '0; dst_hi_q <= '0;
         len_q <= '0; flag_q <= 1'b0; ien_q <= 1'b0;
      end else begin
         if (hit(OFS_SRC_LO)) src_lo_q <= cfg_wdata;
         if (hit(OFS_DST_LO)) dst_lo_q <= cfg_wdata;
         if (hit(OFS_SRC_HI)) src_hi_q <= cfg_wdata[HI_W-1:0];
         if (hit(OFS_DST_HI)) dst_hi_q <= cfg_wdata[HI_W-1:0];
         if (hit(OFS_LEN))    len_q    <= cfg_wdata[LEN_W-1:0];
         if (hit(OFS_IEN))    ien_q    <= cfg_wdata[0];
         // hardware set outranks a software clear in the same cycle
         if (done)                                 flag_q <= 1'b1;
         else if (hit(OFS_FLAG) && cfg_wdata[0])   flag_q <= 1'b0;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         REG_AW'(OFS_FLAG):   cfg_rdata = CFG_W'(flag_q);
         REG_AW'(OFS_IEN):    cfg_rdata = CFG_W'(ien_q);
         REG_AW'(OFS_GO):     cfg_rdata = CFG_W'(busy);
         REG_AW'(OFS_SRC_LO): cfg_rdata = src_lo_q;
         REG_AW'(OFS_DST_LO): cfg_rdata = dst_lo_q;
         REG_AW'(OFS_LEN):    cfg_rdata = CFG_W'(len_q);
         REG_AW'(OFS_SRC_HI): cfg_rdata = CFG_W'(src_hi_q);
         REG_AW'(OFS_DST_HI): cfg_rdata = CFG_W'(dst_hi_q);
         default:             cfg_rdata = '0;
      endcase
   end

   assign src_addr = {src_hi_q, src_lo_q};
   assign dst_addr = {dst_hi_q, dst_lo_q};
   assign len_val  = len_q;
   assign irq_flag = flag_q;
   assign irq_en   = ien_q;

endmodule

// File: rtl/m2m_lane_pack.sv
module m2m_lane_pack #(
   parameter int LANES = 4,
   localparam int LW   = $clog2(LANES),
   localparam int DW   = 8 * LANES
) (
   input  logic [DW-1:0]    rdata,
   input  logic [LW-1:0]    s_off,
   input  logic [LW-1:0]    d_off,
   input  logic [LW:0]      nbytes,
   output logic [DW-1:0]    wdata,
   output logic [LANES-1:0] be
);
   // destination lane j takes source lane s_off + (j - d_off)
   always_comb begin
      be    = '0;
      wdata = '0;
      for (int j = 0; j < LANES; j++) begin
         if ((j >= int'(d_off)) && ((j - int'(d_off)) < int'(nbytes))) begin
            be[j]           = 1'b1;
            wdata[8*j +: 8] = rdata[8*(int'(s_off) + j - int'(d_off)) +: 8];
         end
      end
   end
endmodule

// File: rtl/m2m_mover.sv
module m2m_mover import m2m_copy_pkg::*; #(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 28,
   parameter int LANES  = 4,
   localparam int LW    = $clog2(LANES),
   localparam int DW    = 8 * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              stop,
   input  logic [ADDR_W-1:0] src_in,
   input  logic [ADDR_W-1:0] dst_in,
   input  logic [LEN_W-1:0]  len_in,
   output logic              busy,
   output logic              done,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DW-1:0]     mem_req_wdata,
   output logic [LANES-1:0]  mem_req_be,
   input  logic              mem_rsp_valid,
   input  logic [DW-1:0]     mem_rsp_rdata
);
   mv_state_e         state;
   logic [ADDR_W-1:0] cur_src, cur_dst;
   logic [LEN_W-1:0]  rem;
   logic [DW-1:0]     word_q;
   logic              stop_q;

   logic [LW:0]       s_room, d_room, room, n_chunk;
   logic              last, hs;
   logic [DW-1:0]     pk_data;
   logic [LANES-1:0]  pk_be;

   // bytes this step: limited by remaining count and both word boundaries
   always_comb begin
      s_room  = (LW+1)'(LANES) - (LW+1)'(cur_src[LW-1:0]);
      d_room  = (LW+1)'(LANES) - (LW+1)'(cur_dst[LW-1:0]);
      room    = (s_room < d_room) ? s_room : d_room;
      n_chunk = (rem < LEN_W'(room)) ? rem[LW:0] : room;
      last    = (rem == LEN_W'(n_chunk));
   end

   m2m_lane_pack #(.LANES(LANES)) u_pack (
      .rdata  (word_q),
      .s_off  (cur_src[LW-1:0]),
      .d_off  (cur_dst[LW-1:0]),
      .nbytes (n_chunk),
      .wdata  (pk_data),
      .be     (pk_be)
   );

   assign hs            = mem_req_valid && mem_req_ready;
   assign busy          = (state != MV_IDLE);
   assign mem_req_valid = (state == MV_RD) || (state == MV_WR);
   assign mem_req_write = (state == MV_WR);
   assign mem_req_addr  = (state == MV_WR) ? {cur_dst[ADDR_W-1:LW], {LW{1'b0}}}
                                           : {cur_src[ADDR_W-1:LW], {LW{1'b0}}};
   assign mem_req_wdata = pk_data;
   assign mem_req_be    = (state == MV_WR) ? pk_be : {LANES{1'b1}};
   assign done = !abort &&
                 (((state == MV_WR) && hs && (last || stop_q)) ||
                  ((state == MV_IDLE) && start && (len_in == '0)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= MV_IDLE; cur_src <= '0; cur_dst <= '0; rem <= '0;
         word_q <= '0; stop_q <= 1'b0;
      end else if (abort) begin
         state  <= MV_IDLE;
         stop_q <= 1'b0;
      end else begin
         if (stop && busy) stop_q <= 1'b1;
         case (state)
            MV_IDLE: if (start && (len_in != '0)) begin
               cur_src <= src_in;
               cur_dst <= dst_in;
               rem     <= len_in;
               stop_q  <= 1'b0;
               state   <= MV_RD;
            end
            MV_RD:   if (hs) state <= MV_WAIT;
            MV_WAIT: if (mem_rsp_valid) begin
               word_q <= mem_rsp_rdata;
               state  <= MV_WR;
            end
            MV_WR:   if (hs) begin
               cur_src <= cur_src + ADDR_W'(n_chunk);
               cur_dst <= cur_dst + ADDR_W'(n_chunk);
               rem     <= rem - LEN_W'(n_chunk);
               state   <= (last || stop_q) ? MV_IDLE : MV_RD;
            end
            default: state <= MV_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/m2m_copy_chan.sv
module m2m_copy_chan import m2m_copy_pkg::*; #(
   parameter int ADDR_W  = 64,
   parameter int LEN_W   = 28,
   parameter int LANES   = 4,
   parameter int REG_AW  = 8,
   parameter bit IRQ_REG = 1'b0,
   localparam int DW     = 8 * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   output logic              irq,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DW-1:0]     mem_req_wdata,
   output logic [LANES-1:0]  mem_req_be,
   input  logic              mem_rsp_valid,
   input  logic [DW-1:0]     mem_rsp_rdata
);
   // elaboration-time parameter checks
   if (ADDR_W <= CFG_W || ADDR_W > 2*CFG_W) begin : g_bad_addr
      $error("ADDR_W must lie in 33..64");
   end
   if (LEN_W > CFG_W || LEN_W <= $clog2(LANES)) begin : g_bad_len
      $error("LEN_W out of range");
   end
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if (REG_AW < 7) begin : g_bad_aw
      $error("REG_AW too narrow for the register map");
   end

   cmd_t              cmd;
   logic              mv_busy, mv_done, mv_abort, irq_flag, irq_en;
   logic [ADDR_W-1:0] src_addr, dst_addr;
   logic [LEN_W-1:0]  len_val;

   m2m_csr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_AW(REG_AW)) u_csr (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(mv_busy),
      .done(mv_done), .cmd(cmd), .src_addr(src_addr), .dst_addr(dst_addr),
      .len_val(len_val), .irq_flag(irq_flag), .irq_en(irq_en)
   );

   assign mv_abort = cmd.warm | cmd.hard;

   m2m_mover #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES)) u_mv (
      .clk(clk), .rst_n(rst_n), .start(cmd.start), .abort(mv_abort),
      .stop(cmd.stop), .src_in(src_addr), .dst_in(dst_addr), .len_in(len_val),
      .busy(mv_busy), .done(mv_done), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_req_be(mem_req_be), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata)
   );

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_flag & irq_en;
      end
   end else begin : g_irq_comb
      assign irq = irq_flag & irq_en;
   end

endmodule

// File: rtl/m2m_copy_chan_chk.sv
module m2m_copy_chan_chk #(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 28,
   parameter int LANES  = 4,
   localparam int LW    = $clog2(LANES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_write,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [LANES-1:0]  mem_req_be,
   input logic              busy,
   input logic              abort,
   input logic              hard,
   input logic              irq,
   input logic              flag,
   input logic              ien,
   input logic [LEN_W-1:0]  len
);
   p_word_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[LW-1:0] == '0));

   p_read_full_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |-> (&mem_req_be));

   p_write_some_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> (mem_req_be != '0));

   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready && !abort) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

   p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !mem_req_valid));

   p_hard_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hard |=> (!flag && !ien && (len == '0)));

   p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien || $past(ien)));
endmodule

bind m2m_copy_chan m2m_copy_chan_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
   .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be), .busy(mv_busy),
   .abort(mv_abort), .hard(cmd.hard), .irq(irq), .flag(irq_flag),
   .ien(irq_en), .len(len_val)
);

// File: tb/m2m_copy_chan_test.sv
module m2m_copy_chan_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        irq;
   logic        mem_req_valid, mem_req_ready, mem_req_write;
   logic [63:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic [3:0]  mem_req_be;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_rdata;

   int checks = 0, fails = 0;
   int req_count = 0, bad_hi = 0, cyc = 0;
   logic hold_rd = 1'b0, hold_wr = 1'b0, jitter = 1'b0;
   logic [31:0] exp_hi = '0;
   logic [7:0] mem [256];
   logic [7:0] exp [256];

   // src[31:24] dst[23:16] len[15:8] hi-tag[7:0]
   localparam logic [31:0] VEC [6] = '{
      32'h00_80_10_00, 32'h01_80_09_01, 32'h03_86_0D_7F,
      32'h02_81_01_00, 32'h05_9B_21_55, 32'h06_A2_03_00 };

   always #4 clk = ~clk;

   m2m_copy_chan uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
   );

   assign mem_req_ready = !(hold_rd && !mem_req_write) && !(hold_wr && mem_req_write)
                          && (!jitter || cyc[0]);

   // memory model: read data returned the cycle after acceptance
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) mem_rsp_valid <= 1'b0;
      else begin
         mem_rsp_valid <= 1'b0;
         if (mem_req_valid && mem_req_ready) begin
            req_count <= req_count + 1;
            if (mem_req_addr[63:32] != exp_hi) bad_hi <= bad_hi + 1;
            if (mem_req_write) begin
               for (int b = 0; b < 4; b++)
                  if (mem_req_be[b]) mem[8'(mem_req_addr[7:0] + 8'(b))] <= mem_req_wdata[8*b +: 8];
            end else begin
               mem_rsp_valid <= 1'b1;
               for (int b = 0; b < 4; b++)
                  mem_rsp_rdata[8*b +: 8] <= mem[8'(mem_req_addr[7:0] + 8'(b))];
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic init_mem();
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i * 7 + 3);
         exp[i] = 8'(i * 7 + 3);
      end
   endtask

   task automatic program_regs(input logic [7:0] s, input logic [7:0] d, input logic [31:0] n, input logic [31:0] hi);
      exp_hi = hi;
      cfg_write(8'h1C, {24'h0, s});
      cfg_write(8'h60, hi);
      cfg_write(8'h20, {24'h0, d});
      cfg_write(8'h64, hi);
      cfg_write(8'h24, n);
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      for (int k = 0; k < 3000; k++) begin
         cfg_read(8'h08, d);
         if (d[0] == 1'b0) break;
         @(negedge clk);
      end
   endtask

   task automatic cmp_mem(input string req);
      int miss = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp[i]) miss++;
      check(miss == 0, req, 64'(miss), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int base;
      init_mem();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      begin
         int nz = 0;
         foreach (VEC[i]) ;
         for (int k = 0; k < 10; k++) begin
            logic [7:0] offs [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h1C, 8'h20, 8'h24, 8'h60, 8'h64};
            cfg_read(offs[k], d);
            if (d != 0) nz++;
         end
         check(nz == 0, "R1 reset values zero", 64'(nz), 64'd0);
         check(irq == 1'b0, "R6 irq low after reset", 64'(irq), 64'd0);
      end

      // R1: readback and field widths
      cfg_write(8'h24, 32'hFFFF_FFFF);
      cfg_read(8'h24, d); check(d == 32'h0FFF_FFFF, "R1 count is 28 bits", 64'(d), 64'h0FFF_FFFF);
      cfg_write(8'h60, 32'h1234_5678);
      cfg_read(8'h60, d); check(d == 32'h1234_5678, "R1 source high", 64'(d), 64'h1234_5678);
      cfg_write(8'h20, 32'hDEAD_BEEF);
      cfg_read(8'h20, d); check(d == 32'hDEAD_BEEF, "R1 destination low", 64'(d), 64'hDEAD_BEEF);
      cfg_write(8'h64, 32'h0BAD_F00D);
      cfg_read(8'h64, d); check(d == 32'h0BAD_F00D, "R1 destination high", 64'(d), 64'h0BAD_F00D);

      // table of copies: R2, R3, R5
      for (int v = 0; v < 6; v++) begin
         logic [7:0] s, dd, n;
         s = VEC[v][31:24]; dd = VEC[v][23:16]; n = VEC[v][15:8];
         init_mem();
         for (int k = 0; k < int'(n); k++) exp[8'(dd + 8'(k))] = mem[8'(s + 8'(k))];
         jitter = v[0];
         bad_hi = 0;
         program_regs(s, dd, {24'h0, n}, {VEC[v][7:0], 24'h000001});
         cfg_write(8'h08, 32'h1);
         wait_idle();
         jitter = 1'b0;
         cmp_mem($sformatf("R3 copy vector %0d", v));
         check(bad_hi == 0, "R3 upper address bits", 64'(bad_hi), 64'd0);
         cfg_read(8'h00, d); check(d[0] == 1'b1, "R5 flag set on completion", 64'(d), 64'd1);
         cfg_read(8'h08, d); check(d[0] == 1'b0, "R2 go reads 0 when done", 64'(d), 64'd0);
         cfg_write(8'h00, 32'h1);
      end

      // R5: write 0 keeps flag, write 1 clears; R6 irq tracking
      init_mem();
      program_regs(8'h10, 8'h90, 32'd4, 32'h0);
      for (int k = 0; k < 4; k++) exp[8'h90 + k] = mem[8'h10 + k];
      cfg_write(8'h08, 32'h1);
      wait_idle();
      cfg_write(8'h00, 32'h0);
      cfg_read(8'h00, d); check(d[0] == 1'b1, "R5 writing 0 keeps flag", 64'(d), 64'd1);
      check(irq == 1'b0, "R6 irq masked", 64'(irq), 64'd0);
      cfg_write(8'h04, 32'h1);
      check(irq == 1'b1, "R6 irq when flag and enable", 64'(irq), 64'd1);
      cfg_write(8'h00, 32'h1);
      cfg_read(8'h00, d); check(d[0] == 1'b0, "R5 write 1 clears", 64'(d), 64'd0);
      check(irq == 1'b0, "R6 irq drops with flag", 64'(irq), 64'd0);
      cfg_write(8'h04, 32'h0);

      // R7: zero count
      base = req_count;
      cfg_write(8'h24, 32'h0);
      cfg_write(8'h08, 32'h1);
      cfg_read(8'h00, d); check(d[0] == 1'b1, "R7 zero count sets flag", 64'(d), 64'd1);
      repeat (4) @(negedge clk);
      check(req_count == base, "R7 zero count no requests", 64'(req_count - base), 64'd0);
      cfg_write(8'h00, 32'h1);

      // R5: completion and clear in the same cycle
      init_mem();
      program_regs(8'h20, 8'hA0, 32'd4, 32'h0);
      for (int k = 0; k < 4; k++) exp[8'hA0 + k] = mem[8'h20 + k];
      hold_wr = 1'b1;
      cfg_write(8'h08, 32'h1);
      for (int k = 0; k < 100 && !(mem_req_valid && mem_req_write); k++) @(negedge clk);
      hold_wr = 1'b0;
      cfg_write(8'h00, 32'h1);
      cfg_read(8'h00, d); check(d[0] == 1'b1, "R5 set wins over same-cycle clear", 64'(d), 64'd1);
      cmp_mem("R3 collision copy");
      cfg_write(8'h00, 32'h1);
      cfg_read(8'h00, d); check(d[0] == 1'b0, "R5 later clear", 64'(d), 64'd0);

      // R8: warm abort
      init_mem();
      program_regs(8'h30, 8'hB0, 32'd12, 32'h0);
      hold_rd = 1'b1;
      cfg_write(8'h08, 32'h1);
      cfg_read(8'h08, d); check(d[0] == 1'b1, "R2 go reads 1 while running", 64'(d), 64'd1);
      cfg_write(8'h0C, 32'h1);
      base = req_count;
      hold_rd = 1'b0;
      repeat (6) @(negedge clk);
      cfg_read(8'h08, d); check(d[0] == 1'b0, "R8 idle after warm abort", 64'(d), 64'd0);
      check(req_count == base, "R8 no requests after warm abort", 64'(req_count - base), 64'd0);
      cfg_read(8'h00, d); check(d[0] == 1'b0, "R8 flag stays clear", 64'(d), 64'd0);
      cfg_read(8'h1C, d); check(d == 32'h30, "R8 source kept", 64'(d), 64'h30);
      cfg_read(8'h24, d); check(d == 32'd12, "R8 count kept", 64'(d), 64'd12);
      cmp_mem("R8 destination untouched");

      // R10: graceful stop after one word step
      init_mem();
      program_regs(8'h10, 8'h90, 32'd12, 32'h0);
      for (int k = 0; k < 4; k++) exp[8'h90 + k] = mem[8'h10 + k];
      hold_rd = 1'b1;
      cfg_write(8'h08, 32'h1);
      cfg_write(8'h14, 32'h1);
      hold_rd = 1'b0;
      wait_idle();
      cmp_mem("R10 only current step written");
      cfg_read(8'h00, d); check(d[0] == 1'b1, "R10 flag set on stop", 64'(d), 64'd1);
      cfg_write(8'h00, 32'h1);

      // R11: second go while running is ignored
      init_mem();
      program_regs(8'h40, 8'hC0, 32'd8, 32'h0);
      for (int k = 0; k < 8; k++) exp[8'hC0 + k] = mem[8'h40 + k];
      base = req_count;
      cfg_write(8'h08, 32'h1);
      cfg_write(8'h08, 32'h1);
      wait_idle();
      repeat (6) @(negedge clk);
      check(req_count - base == 4, "R11 request count unchanged", 64'(req_count - base), 64'd4);
      cmp_mem("R11 copy intact");
      cfg_write(8'h00, 32'h1);

      // R9: hard abort clears everything
      init_mem();
      program_regs(8'h50, 8'hD0, 32'd8, 32'h0);
      cfg_write(8'h04, 32'h1);
      hold_rd = 1'b1;
      cfg_write(8'h08, 32'h1);
      cfg_write(8'h0C, 32'h2);
      hold_rd = 1'b0;
      repeat (4) @(negedge clk);
      begin
         int nz = 0;
         for (int k = 0; k < 10; k++) begin
            logic [7:0] offs [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h1C, 8'h20, 8'h24, 8'h60, 8'h64};
            cfg_read(offs[k], d);
            if (d != 0) nz++;
         end
         check(nz == 0, "R9 all registers zero", 64'(nz), 64'd0);
      end
      check(irq == 1'b0, "R9 irq low after hard abort", 64'(irq), 64'd0);
      cmp_mem("R9 destination untouched");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule